// File: doc/BRIEF.md
# Indirect Expansion Bus Access Window

This block gives host software a narrow, register-mapped window onto an external expansion bus that carries both SRAM and Flash devices. Software first loads a 16-bit lower address register and an upper register that holds a 4-bit address extension plus two control bits. It then reads or writes a 16-bit data port. Each data port access hands one bus cycle to a downstream cycle engine over a request/acknowledge handshake. A mode bit in the upper register marks the cycle as Flash or SRAM.

The lower address can be set to step forward by one after every completed access. This lets software stream through a device without reloading the address. Writes to the address and control fields are gated by a stop input and a configured SRAM size. A hard reset and a soft reset treat the fields differently.

The data port is word-only. To change one byte of SRAM, software reads the word, merges the byte and writes the word back. To read one byte, it picks the byte out of the returned word.

Top module: `xbus_port`

## Requirements
- R1: After hard reset (`rst_n` low) the mode bit and the increment bit read 0. This implementation also clears both address fields to 0. `eng_req` and `host_busy` are low.
- R2: A host request with `host_sel`=2 (data port) while idle raises `eng_req` and `host_busy` on the next cycle, with `eng_we` equal to `host_wr`. Both stay high until the first cycle in which `eng_ack` is sampled high, and are low on the cycle after that.
- R3: On a data port write, `eng_wdata` carries `host_wdata[15:0]` for the whole access. On a data port read, `eng_rdata` is captured at the acknowledge and then reads back at `host_rdata[15:0]` with `host_sel`=2.
- R4: Upper register bit 15 is the mode bit. When it is 1, `eng_flash` is 1 and `eng_addr` is {upper field, lower address}. When it is 0, `eng_flash` is 0 and `eng_addr[19:16]` is 0.
- R5: Upper register bit 14 is the increment bit. When it is 1, the lower address (`host_sel`=0, bits 15:0) grows by one after each acknowledged access. When it is 0, the lower address is left unchanged.
- R6: With the increment bit set, a lower address of FFFFh becomes 0000h after the access, and the upper field is unchanged.
- R7: The mode and increment bits change on a write to `host_sel`=1 only while `stop` is 1.
- R8: The lower address and the upper field (`host_sel`=1, bits 3:0) accept writes only while `stop` is 1 or `sram_size` is 0.
- R9: Reserved bits read as 0 and ignore writes. These are bits 31:16 of every register and bits 13:4 of the upper register. `host_sel`=3 reads all zeros.
- R10: A soft reset (`soft_rst` high) leaves the mode bit, the increment bit and both address fields unchanged. It aborts a pending access: `eng_req` and `host_busy` are low on the next cycle and the address does not advance.
- R11: Host requests made while `host_busy` is high are ignored. No register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hard reset, synchronous, active low |
| soft_rst | input | 1 | Soft reset, synchronous, active high |
| stop | input | 1 | Stop condition, unlocks control and address writes |
| sram_size | input | 8 | Configured SRAM size; zero unlocks address writes |
| host_req | input | 1 | Host access strobe, one cycle |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_sel | input | 2 | 0 lower address, 1 upper/control, 2 data port, 3 unused |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read view of the selected register |
| host_busy | output | 1 | Data port access in progress |
| eng_req | output | 1 | Bus cycle request to the cycle engine |
| eng_we | output | 1 | Bus cycle direction, 1 = write |
| eng_flash | output | 1 | Cycle type, 1 = Flash, 0 = SRAM |
| eng_addr | output | 20 | Bus cycle address |
| eng_wdata | output | 16 | Bus cycle write data |
| eng_ack | input | 1 | Cycle engine acknowledge |
| eng_rdata | input | 16 | Read data from the cycle engine, valid with `eng_ack` |

## Verification
The assertions assume that `eng_ack` is only raised while `eng_req` is high, and that `stop` and `sram_size` are set only while no data port access is pending. The assertions on address stepping also assume the host does not write the lower address in the cycle it is acknowledged. The busy lockout rules that case out, since writes are refused while an access is pending. The stimulus follows these rules by construction. The bench's engine model raises the acknowledge only after it has seen the request, and after a chosen delay of zero to two cycles. The lock inputs change only between accesses. The only host traffic sent during a pending access is the deliberate lockout and soft reset cases.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
   typedef enum logic [1:0] {
      SEL_LO   = 2'd0,
      SEL_HI   = 2'd1,
      SEL_DATA = 2'd2,
      SEL_NONE = 2'd3
   } xbus_sel_e;

   localparam int MODE_BIT = 15;
   localparam int INC_BIT  = 14;
endpackage

// File: rtl/xbus_addr_regs.sv
module xbus_addr_regs #(
   parameter int LO_W   = 16,
   parameter int HI_W   = 4,
   parameter int SIZE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stop,
   input  logic [SIZE_W-1:0] sram_size,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic [LO_W-1:0]   lo_val,
   input  logic [HI_W-1:0]   hi_val,
   input  logic              mode_val,
   input  logic              inc_val,
   input  logic              step,
   output logic [LO_W-1:0]   lo_q,
   output logic [HI_W-1:0]   hi_q,
   output logic              mode_q,
   output logic              inc_q
);
   logic addr_open;
   logic ctrl_open;

   assign addr_open = stop | (sram_size == '0);
   assign ctrl_open = stop;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo_q   <= '0;
         hi_q   <= '0;
         mode_q <= 1'b0;
         inc_q  <= 1'b0;
      end else begin
         if (wr_lo && addr_open)
            lo_q <= lo_val;
         else if (step && inc_q)
            lo_q <= lo_q + 1'b1;
         if (wr_hi && addr_open)
            hi_q <= hi_val;
         if (wr_hi && ctrl_open) begin
            mode_q <= mode_val;
            inc_q  <= inc_val;
         end
      end
   end

   AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      step && inc_q && !wr_lo |=> lo_q == LO_W'($past(lo_q) + 1'b1)); // R5
   AST_STEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      step && !inc_q && !wr_lo |=> $stable(lo_q)); // R5
   AST_CTRL_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      !stop |=> $stable({mode_q, inc_q})); // R7
   AST_UPPER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      !stop && (sram_size != '0) |=> $stable(hi_q)); // R8
endmodule

// File: rtl/xbus_cycle_ctl.sv
module xbus_cycle_ctl #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst,
   input  logic              start,
   input  logic              start_we,
   input  logic [DATA_W-1:0] wdata,
   input  logic              eng_ack,
   input  logic [DATA_W-1:0] eng_rdata,
   output logic              busy,
   output logic              we_q,
   output logic              done,
   output logic [DATA_W-1:0] data_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         we_q   <= 1'b0;
         data_q <= '0;
      end else if (soft_rst) begin
         busy <= 1'b0;
      end else if (!busy && start) begin
         busy <= 1'b1;
         we_q <= start_we;
         if (start_we)
            data_q <= wdata;
      end else if (busy && eng_ack) begin
         busy <= 1'b0;
         if (!we_q)
            data_q <= eng_rdata;
      end
   end

   assign done = busy & eng_ack & ~soft_rst;

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !eng_ack && !soft_rst |=> busy); // R2
   AST_ACK_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      busy && eng_ack |=> !busy); // R2
   AST_WDATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !eng_ack |=> $stable(data_q)); // R3
   AST_SOFT_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> !busy); // R10
endmodule

// File: rtl/xbus_port.sv
module xbus_port
   import xbus_pkg::*;
#(
   parameter int  HOST_W          = 32,
   parameter int  LO_W            = 16,
   parameter int  HI_W            = 4,
   parameter int  DATA_W          = 16,
   parameter int  SIZE_W          = 8,
   parameter bit  SRAM_MASK_UPPER = 1'b1,
   localparam int ADDR_W          = LO_W + HI_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst,
   input  logic              stop,
   input  logic [SIZE_W-1:0] sram_size,
   input  logic              host_req,
   input  logic              host_wr,
   input  logic [1:0]        host_sel,
   input  logic [HOST_W-1:0] host_wdata,
   output logic [HOST_W-1:0] host_rdata,
   output logic              host_busy,
   output logic              eng_req,
   output logic              eng_we,
   output logic              eng_flash,
   output logic [ADDR_W-1:0] eng_addr,
   output logic [DATA_W-1:0] eng_wdata,
   input  logic              eng_ack,
   input  logic [DATA_W-1:0] eng_rdata
);
   if (LO_W != 16 || DATA_W != 16) begin : g_bad_width
      $error("xbus_port: LO_W and DATA_W must both be 16");
   end
   if (HI_W < 1 || HI_W > INC_BIT) begin : g_bad_upper
      $error("xbus_port: HI_W must lie in 1..14");
   end
   if (HOST_W <= MODE_BIT + 1) begin : g_bad_host
      $error("xbus_port: HOST_W must exceed 16");
   end

   xbus_sel_e         sel;
   logic              busy;
   logic              accept;
   logic              wr_lo;
   logic              wr_hi;
   logic              start;
   logic              done;
   logic [LO_W-1:0]   lo_q;
   logic [HI_W-1:0]   hi_q;
   logic              mode_q;
   logic              inc_q;
   logic [DATA_W-1:0] data_q;
   logic              unused_wbits;

   assign sel          = xbus_sel_e'(host_sel);
   assign accept       = host_req & ~busy & ~soft_rst;
   assign wr_lo        = accept & host_wr & (sel == SEL_LO);
   assign wr_hi        = accept & host_wr & (sel == SEL_HI);
   assign start        = accept & (sel == SEL_DATA);
   assign unused_wbits = ^host_wdata[HOST_W-1:MODE_BIT+1];

   xbus_addr_regs #(.LO_W(LO_W), .HI_W(HI_W), .SIZE_W(SIZE_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .stop      (stop),
      .sram_size (sram_size),
      .wr_lo     (wr_lo),
      .wr_hi     (wr_hi),
      .lo_val    (host_wdata[LO_W-1:0]),
      .hi_val    (host_wdata[HI_W-1:0]),
      .mode_val  (host_wdata[MODE_BIT]),
      .inc_val   (host_wdata[INC_BIT]),
      .step      (done),
      .lo_q      (lo_q),
      .hi_q      (hi_q),
      .mode_q    (mode_q),
      .inc_q     (inc_q)
   );

   xbus_cycle_ctl #(.DATA_W(DATA_W)) u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .soft_rst  (soft_rst),
      .start     (start),
      .start_we  (host_wr),
      .wdata     (host_wdata[DATA_W-1:0]),
      .eng_ack   (eng_ack),
      .eng_rdata (eng_rdata),
      .busy      (busy),
      .we_q      (eng_we),
      .done      (done),
      .data_q    (data_q)
   );

   assign host_busy = busy;
   assign eng_req   = busy;
   assign eng_flash = mode_q;
   assign eng_wdata = data_q;

   if (SRAM_MASK_UPPER) begin : g_mask_upper
      assign eng_addr = mode_q ? {hi_q, lo_q} : {{HI_W{1'b0}}, lo_q};

      AST_SRAM_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
         eng_req && !eng_flash |-> eng_addr[ADDR_W-1:LO_W] == '0); // R4
   end else begin : g_full_upper
      assign eng_addr = {hi_q, lo_q};
   end

   always_comb begin
      host_rdata = '0;
      case (sel)
         SEL_LO:   host_rdata[LO_W-1:0] = lo_q;
         SEL_HI: begin
            host_rdata[MODE_BIT]  = mode_q;
            host_rdata[INC_BIT]   = inc_q;
            host_rdata[HI_W-1:0]  = hi_q;
         end
         SEL_DATA: host_rdata[DATA_W-1:0] = data_q;
         default:  host_rdata = '0;
      endcase
   end

   AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
      busy && host_req && !eng_ack && !soft_rst |=> $stable({mode_q, inc_q, hi_q, lo_q})); // R11
   AST_ADDR_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
      eng_req && !eng_ack && !soft_rst |=> $stable(eng_addr) && $stable(eng_flash)); // R4
   AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      host_rdata[HOST_W-1:MODE_BIT+1] == '0); // R9
endmodule

// File: tb/xbus_port_test.sv
module xbus_port_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        soft_rst = 1'b0;
   logic        stop = 1'b0;
   logic [7:0]  sram_size = 8'h00;
   logic        host_req = 1'b0;
   logic        host_wr = 1'b0;
   logic [1:0]  host_sel = 2'd0;
   logic [31:0] host_wdata = '0;
   logic [31:0] host_rdata;
   logic        host_busy;
   logic        eng_req;
   logic        eng_we;
   logic        eng_flash;
   logic [19:0] eng_addr;
   logic [15:0] eng_wdata;
   logic        eng_ack = 1'b0;
   logic [15:0] eng_rdata = '0;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   xbus_port uut (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .stop(stop), .sram_size(sram_size),
      .host_req(host_req), .host_wr(host_wr), .host_sel(host_sel), .host_wdata(host_wdata),
      .host_rdata(host_rdata), .host_busy(host_busy), .eng_req(eng_req), .eng_we(eng_we),
      .eng_flash(eng_flash), .eng_addr(eng_addr), .eng_wdata(eng_wdata),
      .eng_ack(eng_ack), .eng_rdata(eng_rdata)
   );

   function automatic logic [15:0] mem_model(input logic [19:0] a);
      return a[15:0] ^ 16'hC3A5 ^ {a[19:16], 12'h000};
   endfunction

   function automatic logic [31:0] hi_word(input bit m, input bit i, input logic [3:0] h);
      return {16'h0000, m, i, 10'h000, h};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [1:0] s, input logic [31:0] d);
      @(negedge clk);
      host_req = 1'b1; host_wr = 1'b1; host_sel = s; host_wdata = d;
      @(negedge clk);
      host_req = 1'b0; host_wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [1:0] s, output logic [31:0] v);
      host_sel = s;
      #1 v = host_rdata;
   endtask

   task automatic data_access(input bit wr, input logic [15:0] wd, input int delay,
                              input logic [19:0] exp_addr, input bit exp_flash);
      @(negedge clk);
      host_req = 1'b1; host_wr = wr; host_sel = 2'd2; host_wdata = {16'hDEAD, wd};
      @(negedge clk);
      host_req = 1'b0; host_wr = 1'b0;
      check("R2 eng_req raised", {31'd0, eng_req}, 32'd1);
      check("R2 host_busy raised", {31'd0, host_busy}, 32'd1);
      check("R2 eng_we", {31'd0, eng_we}, {31'd0, wr});
      check("R4 eng_addr", {12'd0, eng_addr}, {12'd0, exp_addr});
      check("R4 eng_flash", {31'd0, eng_flash}, {31'd0, exp_flash});
      if (wr) check("R3 eng_wdata", {16'd0, eng_wdata}, {16'd0, wd});
      for (int k = 0; k < delay; k++) begin
         @(negedge clk);
         check("R2 eng_req held", {31'd0, eng_req}, 32'd1);
      end
      eng_ack = 1'b1; eng_rdata = mem_model(exp_addr);
      @(negedge clk);
      eng_ack = 1'b0;
      check("R2 eng_req dropped", {31'd0, eng_req}, 32'd0);
      check("R2 host_busy dropped", {31'd0, host_busy}, 32'd0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      bit m_mode, m_inc;
      logic [3:0] m_hi;
      logic [15:0] m_lo;

      repeat (3) @(negedge clk);
      check("R1 eng_req after reset", {31'd0, eng_req}, 32'd0);
      check("R1 host_busy after reset", {31'd0, host_busy}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      rd_reg(2'd1, v); check("R1 upper/control after reset", v, 32'd0);
      rd_reg(2'd0, v); check("R1 lower after reset", v, 32'd0);

      // R7 R8 R9: lock sweep over stop, size and control values
      m_mode = 0; m_inc = 0; m_hi = 0; m_lo = 0;
      for (int s = 0; s < 2; s++) begin
         for (int z = 0; z < 2; z++) begin
            for (int c = 0; c < 4; c++) begin
               logic [3:0] nib;
               logic [15:0] lov;
               nib = 4'(c * 3 + s * 5 + z * 2 + 1);
               lov = 16'(16'h1000 * (c + 1) + s * 16'h10 + z);
               @(negedge clk);
               stop = s[0];
               sram_size = z[0] ? 8'h00 : 8'h20;
               wr_reg(2'd1, {16'hFFFF, c[1], c[0], 10'h3FF, nib});
               wr_reg(2'd0, {16'hFFFF, lov});
               if (s != 0) begin m_mode = c[1]; m_inc = c[0]; end
               if (s != 0 || z != 0) begin m_hi = nib; m_lo = lov; end
               rd_reg(2'd1, v); check("R7 R8 R9 upper/control lock", v, hi_word(m_mode, m_inc, m_hi));
               rd_reg(2'd0, v); check("R8 R9 lower lock", v, {16'd0, m_lo});
            end
         end
      end
      rd_reg(2'd3, v); check("R9 unused select reads zero", v, 32'd0);

      // R3 R4 R5: data port sweep
      stop = 1'b1; sram_size = 8'h20;
      for (int m = 0; m < 2; m++) begin
         for (int i = 0; i < 2; i++) begin
            for (int d = 0; d < 3; d++) begin
               for (int w = 0; w < 2; w++) begin
                  logic [15:0] base;
                  logic [3:0] h;
                  logic [19:0] ea;
                  logic [15:0] wd;
                  base = 16'(16'h2400 + m * 16'h100 + i * 16'h40 + d * 4 + w);
                  h = 4'(9 + m + d);
                  wd = 16'(16'h5A00 + m * 8 + i * 4 + d * 2 + w);
                  wr_reg(2'd1, hi_word(m[0], i[0], h));
                  wr_reg(2'd0, {16'd0, base});
                  ea = m[0] ? {h, base} : {4'h0, base};
                  data_access(w[0], wd, d, ea, m[0]);
                  rd_reg(2'd0, v);
                  check("R5 lower after access", v, {16'd0, 16'(base + i)});
                  rd_reg(2'd2, v);
                  check("R3 data port readback", v, w[0] ? {16'd0, wd} : {16'd0, mem_model(ea)});
               end
            end
         end
      end

      // R6: wrap
      wr_reg(2'd1, hi_word(1'b1, 1'b1, 4'h7));
      wr_reg(2'd0, 32'h0000FFFF);
      data_access(1'b0, 16'h0, 1, 20'h7FFFF, 1'b1);
      rd_reg(2'd0, v); check("R6 wrap to zero", v, 32'd0);
      rd_reg(2'd1, v); check("R6 upper unchanged", v, hi_word(1'b1, 1'b1, 4'h7));

      // R11: requests while busy are ignored
      wr_reg(2'd1, hi_word(1'b0, 1'b1, 4'h3));
      wr_reg(2'd0, 32'h00000100);
      @(negedge clk);
      host_req = 1'b1; host_wr = 1'b0; host_sel = 2'd2;
      @(negedge clk);
      host_req = 1'b0;
      wr_reg(2'd0, 32'h0000BEEF);
      wr_reg(2'd1, hi_word(1'b1, 1'b0, 4'hC));
      check("R11 still busy", {31'd0, host_busy}, 32'd1);
      eng_ack = 1'b1; eng_rdata = 16'h1234;
      @(negedge clk);
      eng_ack = 1'b0;
      rd_reg(2'd0, v); check("R11 lower ignores busy write", v, 32'h00000101);
      rd_reg(2'd1, v); check("R11 control ignores busy write", v, hi_word(1'b0, 1'b1, 4'h3));

      // R10: soft reset aborts, keeps fields
      wr_reg(2'd1, hi_word(1'b1, 1'b1, 4'h5));
      wr_reg(2'd0, 32'h00000200);
      @(negedge clk);
      host_req = 1'b1; host_wr = 1'b1; host_sel = 2'd2; host_wdata = 32'h0000AAAA;
      @(negedge clk);
      host_req = 1'b0; host_wr = 1'b0;
      soft_rst = 1'b1;
      @(negedge clk);
      soft_rst = 1'b0;
      check("R10 eng_req aborted", {31'd0, eng_req}, 32'd0);
      check("R10 host_busy aborted", {31'd0, host_busy}, 32'd0);
      rd_reg(2'd0, v); check("R10 lower kept", v, 32'h00000200);
      rd_reg(2'd1, v); check("R10 control kept", v, hi_word(1'b1, 1'b1, 4'h5));
      data_access(1'b1, 16'h0F0F, 0, 20'h50200, 1'b1);
      rd_reg(2'd0, v); check("R10 works after soft reset", v, 32'h00000201);

      // R1: hard reset clears control bits
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      rd_reg(2'd1, v); check("R1 control cleared by hard reset", v, 32'd0);

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule